// File: doc/BRIEF.md
# 16-bit Pointer Arithmetic Unit

This is a purely combinational unit that performs the 16-bit arithmetic on register pairs and on the stack pointer for a small 8-bit CPU. The unit receives the four 16-bit pairs, a 2-bit pair select, an 8-bit signed offset, a 3-bit operation code and the current flags. It returns a 16-bit result, the new flags, and the index of the pair that should receive the result.

The operations are:

- adding a selected pair to HL;
- adding a sign-extended offset to SP, with the sum sent either to SP or to HL;
- incrementing or decrementing any selected pair;
- the one-step HL adjustment that follows an indirect load or store through HL.

Bus cycles and the sequencing of register writeback belong to the surrounding core. All sums wrap modulo 65536, and no overflow is indicated.

Flags use a 4-bit vector: bit 3 = Z, bit 2 = N, bit 1 = H, bit 0 = C. Pairs are numbered 0 = BC, 1 = DE, 2 = HL, 3 = SP, and this numbering is used by both `pair_sel_i` and `dest_o`.

Top module: `ptr_alu`

## Requirements
- R1: For op 3 and op 4, the operand is the pair chosen by `pair_sel_i` (0=BC, 1=DE, 2=HL, 3=SP), and `dest_o` equals `pair_sel_i`.
- R2: Op 0 (pair add to HL) returns HL + pair modulo 65536 with `dest_o`=2. It sets N=0, sets H when the low 12 bits carry out of bit 11, sets C when the sum carries out of bit 15, and keeps Z from `flags_i`.
- R3: Op 1 returns SP + sign-extended `ofs_i` (range -128..127) modulo 65536, with `dest_o`=3 and Z=0, N=0.
- R4: For op 1 and op 2, H is the carry out of bit 3 and C is the carry out of bit 7 of the unsigned sum of SP[7:0] and `ofs_i`.
- R5: Op 2 gives the same result and flags as op 1 but sets `dest_o`=2.
- R6: Op 3 returns the pair + 1 and op 4 returns the pair - 1, both modulo 65536 (0xFFFF+1=0, 0-1=0xFFFF). Both pass `flags_i` through unchanged.
- R7: Op 5 returns HL + 1 and op 6 returns HL - 1, modulo 65536. Both use `dest_o`=2, keep the flags, and ignore `pair_sel_i`.
- R8: Op 7 is a no-op: the result is HL, the flags are unchanged and `dest_o`=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bc_i | input | 16 | Pair 0 value |
| de_i | input | 16 | Pair 1 value |
| hl_i | input | 16 | Pair 2 value |
| sp_i | input | 16 | Pair 3 value (stack pointer) |
| pair_sel_i | input | 2 | Pair operand select |
| ofs_i | input | 8 | Signed 8-bit offset |
| op_i | input | 3 | Operation code 0..7 |
| flags_i | input | 4 | Current flags {Z,N,H,C} |
| result_o | output | 16 | 16-bit result |
| flags_o | output | 4 | New flags {Z,N,H,C} |
| dest_o | output | 2 | Pair index to receive the result |

## Verification
The assertions are evaluated continuously, whenever the inputs change. They check the following:

- the offset forms always clear Z and N;
- the step operations never alter the flags;
- the pair add keeps Z and clears N;
- the HL steps move HL by exactly one in the right direction;
- the destination index follows the operation.

The carry positions, sign extension and wrap-around values can only be shown by the bench. It compares results computed independently over every offset against a set of stack-pointer values, over many pair-add operand patterns, and over each pair for the step operations.

// File: rtl/ptr_alu.sv
module ptr_alu (
  input  logic [15:0] bc_i,
  input  logic [15:0] de_i,
  input  logic [15:0] hl_i,
  input  logic [15:0] sp_i,
  input  logic [1:0]  pair_sel_i,
  input  logic [7:0]  ofs_i,
  input  logic [2:0]  op_i,
  input  logic [3:0]  flags_i,
  output logic [15:0] result_o,
  output logic [3:0]  flags_o,
  output logic [1:0]  dest_o
);
  localparam logic [1:0] PAIR_HL = 2'd2;
  localparam logic [1:0] PAIR_SP = 2'd3;

  logic [15:0] pair_v;
  always_comb begin
    case (pair_sel_i)
      2'd0:    pair_v = bc_i;
      2'd1:    pair_v = de_i;
      2'd2:    pair_v = hl_i;
      default: pair_v = sp_i;
    endcase
  end

  wire [16:0] pair_sum = {1'b0, hl_i} + {1'b0, pair_v};
  wire [12:0] pair_mid = {1'b0, hl_i[11:0]} + {1'b0, pair_v[11:0]};
  wire [15:0] ofs_ext  = {{8{ofs_i[7]}}, ofs_i};
  wire [15:0] ofs_sum  = sp_i + ofs_ext;
  wire [8:0]  ofs_low  = {1'b0, sp_i[7:0]} + {1'b0, ofs_i};
  wire [4:0]  ofs_nib  = {1'b0, sp_i[3:0]} + {1'b0, ofs_i[3:0]};
  wire [3:0]  ofs_flg  = {2'b00, ofs_nib[4], ofs_low[8]};

  always_comb begin
    result_o = hl_i;
    flags_o  = flags_i;
    dest_o   = PAIR_HL;
    case (op_i)
      3'd0: begin
        result_o = pair_sum[15:0];
        flags_o  = {flags_i[3], 1'b0, pair_mid[12], pair_sum[16]};
      end
      3'd1: begin
        result_o = ofs_sum;
        flags_o  = ofs_flg;
        dest_o   = PAIR_SP;
      end
      3'd2: begin
        result_o = ofs_sum;
        flags_o  = ofs_flg;
      end
      3'd3: begin
        result_o = pair_v + 16'd1;
        dest_o   = pair_sel_i;
      end
      3'd4: begin
        result_o = pair_v - 16'd1;
        dest_o   = pair_sel_i;
      end
      3'd5: result_o = hl_i + 16'd1;
      3'd6: result_o = hl_i - 16'd1;
      default: ;
    endcase
  end
endmodule

// File: rtl/ptr_alu_chk.sv
module ptr_alu_chk (
  input logic [15:0] bc_i,
  input logic [15:0] de_i,
  input logic [15:0] hl_i,
  input logic [15:0] sp_i,
  input logic [1:0]  pair_sel_i,
  input logic [7:0]  ofs_i,
  input logic [2:0]  op_i,
  input logic [3:0]  flags_i,
  input logic [15:0] result_o,
  input logic [3:0]  flags_o,
  input logic [1:0]  dest_o
);
  wire known = !$isunknown({bc_i, de_i, hl_i, sp_i, pair_sel_i, ofs_i, op_i, flags_i});

  always_comb begin
    if (known) begin
      if (op_i == 3'd1 || op_i == 3'd2)
        AST_OFS_ZN_CLEAR: assert (flags_o[3:2] == 2'b00); // R3
      if (op_i >= 3'd3)
        AST_STEP_FLAGS_KEPT: assert (flags_o == flags_i); // R6
      if (op_i == 3'd0)
        AST_PAIR_ADD_Z_KEPT: assert (flags_o[3] == flags_i[3] && !flags_o[2]); // R2
      if (op_i == 3'd5)
        AST_HL_STEP_UP: assert (16'(result_o - hl_i) == 16'd1); // R7
      if (op_i == 3'd6)
        AST_HL_STEP_DOWN: assert (16'(hl_i - result_o) == 16'd1); // R7
      if (op_i == 3'd3 || op_i == 3'd4)
        AST_STEP_DEST: assert (dest_o == pair_sel_i); // R1
      if (op_i == 3'd1)
        AST_SP_DEST: assert (dest_o == 2'd3); // R3
      if (op_i == 3'd2 || op_i == 3'd0 || op_i >= 3'd5)
        AST_HL_DEST: assert (dest_o == 2'd2); // R5
    end
  end
endmodule

bind ptr_alu ptr_alu_chk i_chk (.*);

// File: tb/test_ptr_alu.sv
module test_ptr_alu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] bc, de, hl, sp;
  logic [1:0]  psel;
  logic [7:0]  ofs;
  logic [2:0]  op;
  logic [3:0]  fin;
  logic [15:0] res;
  logic [3:0]  fout;
  logic [1:0]  dest;

  ptr_alu i_ptr_alu (
    .bc_i(bc), .de_i(de), .hl_i(hl), .sp_i(sp), .pair_sel_i(psel),
    .ofs_i(ofs), .op_i(op), .flags_i(fin),
    .result_o(res), .flags_o(fout), .dest_o(dest)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic apply(input logic [2:0] o, input logic [1:0] s, input logic [7:0] f8,
                       input logic [3:0] fl);
    @(negedge clk);
    op = o; psel = s; ofs = f8; fin = fl;
    #1;
  endtask

  task automatic chk(input string tag, input logic [15:0] er, input logic [3:0] ef,
                     input logic [1:0] ed);
    checks++;
    if (res !== er || fout !== ef || dest !== ed) begin
      errors++;
      $display("FAIL %s op=%0d: result=%h flags=%b dest=%0d expected result=%h flags=%b dest=%0d",
               tag, op, res, fout, dest, er, ef, ed);
    end
  endtask

  function automatic logic [15:0] pick(input int s);
    case (s)
      0: pick = bc;
      1: pick = de;
      2: pick = hl;
      default: pick = sp;
    endcase
  endfunction

  initial begin
    int sp_list [8] = '{0, 'h000F, 'h00FF, 'h0080, 'h7FFF, 'hFFFF, 'h1234, 'hFFF8};
    int v_list [5]  = '{0, 1, 'h8000, 'hFFFF, 'h0FFF};
    bc = 0; de = 0; hl = 0; sp = 0; psel = 0; ofs = 0; op = 7; fin = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset-state", 16'h0000, 4'h0, 2'd2);
    rst_n = 1'b1;

    // R2: pair add sweep
    for (int i = 0; i < 1200; i++) begin
      int a, b, s, sum;
      logic [3:0] ef;
      a = (i * 40503 + 11) % 65536;
      b = (i * 12345 + 777) % 65536;
      if (i == 0) begin a = 'hFFFF; b = 1; end
      if (i == 1) begin a = 'h0FFF; b = 1; end
      if (i == 2) begin a = 'h8000; b = 'h8000; end
      s = i % 4;
      @(negedge clk);
      hl = 16'(a); bc = 16'(b); de = 16'(b ^ 'h5A5A); sp = 16'(b + 3);
      apply(3'd0, 2'(s), 8'(i), 4'(i));
      b = pick(s);
      sum = a + b;
      ef = {fin[3], 1'b0, ((a % 4096) + (b % 4096)) >= 4096, sum >= 65536};
      chk("R2 pair-add", 16'(sum % 65536), ef, 2'd2);
    end

    // R3 R4 R5: every offset against several SP values
    for (int k = 0; k < 8; k++) begin
      for (int f = 0; f < 256; f++) begin
        int so, sum;
        logic [3:0] ef;
        sp = 16'(sp_list[k]); hl = 16'h4321;
        so = (f >= 128) ? f - 256 : f;
        sum = (sp_list[k] + so + 65536) % 65536;
        ef = {2'b00, ((sp_list[k] % 16) + (f % 16)) >= 16, ((sp_list[k] % 256) + f) >= 256};
        apply(3'd1, 2'(f), 8'(f), 4'hF);
        chk("R3/R4 sp-offset", 16'(sum), ef, 2'd3);
        apply(3'd2, 2'(f), 8'(f), 4'(f));
        chk("R5 hl-from-sp-offset", 16'(sum), ef, 2'd2);
      end
    end

    // R1 R6: step of each pair
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 5; v++) begin
        @(negedge clk);
        bc = 16'h1111; de = 16'h2222; hl = 16'h3333; sp = 16'h4444;
        case (s)
          0: bc = 16'(v_list[v]);
          1: de = 16'(v_list[v]);
          2: hl = 16'(v_list[v]);
          default: sp = 16'(v_list[v]);
        endcase
        apply(3'd3, 2'(s), 8'h00, 4'(s * 5 + v));
        chk("R1/R6 inc-pair", 16'((v_list[v] + 1) % 65536), 4'(s * 5 + v), 2'(s));
        apply(3'd4, 2'(s), 8'h00, 4'(v + 9));
        chk("R1/R6 dec-pair", 16'((v_list[v] + 65535) % 65536), 4'(v + 9), 2'(s));
      end
    end

    // R7 HL post-step, R8 no-op, pair select ignored
    for (int v = 0; v < 5; v++) begin
      for (int s = 0; s < 4; s++) begin
        @(negedge clk);
        hl = 16'(v_list[v]); bc = 16'hAAAA; de = 16'hBBBB; sp = 16'hCCCC;
        apply(3'd5, 2'(s), 8'h7F, 4'(v + s));
        chk("R7 hl-post-inc", 16'((v_list[v] + 1) % 65536), 4'(v + s), 2'd2);
        apply(3'd6, 2'(s), 8'h80, 4'(v * 3));
        chk("R7 hl-post-dec", 16'((v_list[v] + 65535) % 65536), 4'(v * 3), 2'd2);
        apply(3'd7, 2'(s), 8'hFF, 4'(15 - v));
        chk("R8 no-op", 16'(v_list[v]), 4'(15 - v), 2'd2);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: bench did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule